// File: doc/BRIEF.md
# Cascaded First-Order IIR Level Estimator

This block is the level-measuring front end of a dynamic range compressor for one audio channel. It takes the samples that leave the digital volume stage. Each sample runs through a programmable first-order high-pass section, which strips DC and very-low-frequency content that would distort the level estimate. The result then runs through a programmable first-order low-pass section, which smooths it into a slowly moving value. A downstream gain computer, which is outside this block, reads that value to find quiet passages and peaks.

Both sections compute `y[n] = (c_ff0*x[n] + c_ff1*x[n-1] + c_fb*y[n-1]) / 2^23`. The six 24-bit two's-complement coefficients are loaded through a small write port. A write is staged so that every sample is filtered with a single, consistent coefficient set. A single enable turns the estimator off. While it is off, the filter history is held at zero and no results are produced.

Top module: `lvl_est_iir`

## Requirements
- R1: Each sample passes first through the high-pass section and then through the low-pass section. Each section forms the exact sum of its three products, adds 2^22 and shifts arithmetically right by 23 bits, so that ties round toward plus infinity.
- R2: A section result outside the 24-bit signed range is clamped to 8388607 or to -8388608.
- R3: The sum of three full-scale products, up to 3·2^46 in magnitude, is formed without wrap-around before rounding and clamping.
- R4: `out_vld` pulses high for exactly one cycle, two clock cycles after each cycle in which `in_vld` is high with `enable` high. Samples on consecutive cycles give results on consecutive cycles.
- R5: `out_data` keeps its value between `out_vld` pulses.
- R6: While `enable` is low, both sections hold zero history, `out_data` is zero and `out_vld` stays low. A sample in flight when `enable` falls is dropped. After `enable` returns high, filtering restarts from zero history.
- R7: A pulse on `cfg_we` writes `cfg_data` into the coefficient chosen by `cfg_sel`: 0 high-pass c_ff0, 1 high-pass c_ff1, 2 high-pass c_fb, 3 low-pass c_ff0, 4 low-pass c_ff1, 5 low-pass c_fb. A sample uses the coefficients written in earlier cycles. A write in the same cycle as the sample's `in_vld` applies only from the next sample on, and this holds for both sections.
- R8: Writes with `cfg_sel` equal to 6 or 7 change no coefficient.
- R9: After reset all coefficients are zero, `out_vld` is low and `out_data` is zero, so the first sample gives a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Estimator on; low clears the history and silences the output |
| in_vld | input | 1 | Sample strobe |
| in_data | input | SAMPLE_W | Signed post-volume sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 3 | Coefficient index (R7 encoding) |
| cfg_data | input | COEF_W | Signed coefficient value |
| out_vld | output | 1 | Result strobe |
| out_data | output | SAMPLE_W | Signed smoothed level value |

## Verification
The hardest case to reach from the ports is a coefficient write that lands while a sample sits between the two sections. In that case the low-pass stage must still use the value from before the write. The bench raises `cfg_we` for a low-pass coefficient in the same cycle as `in_vld`, and compares the result against a model that applies the write only after that sample. The second hard case is a 48-bit accumulator wrap, which needs three full-scale products of the same sign. The bench drives the high-pass section at full scale with a positive feedback term, so that the feedback product adds to both feed-forward products.

// File: rtl/lvl_est_pkg.sv
package lvl_est_pkg;
  localparam int SEL_W  = 3;
  localparam int NCOEF  = 6;

  typedef enum logic [SEL_W-1:0] {
    CS_HP_FF0 = 3'd0,
    CS_HP_FF1 = 3'd1,
    CS_HP_FB  = 3'd2,
    CS_LP_FF0 = 3'd3,
    CS_LP_FF1 = 3'd4,
    CS_LP_FB  = 3'd5
  } coef_sel_e;
endpackage

// File: rtl/lvl_coef_bank.sv
module lvl_coef_bank #(
  parameter int CW = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [lvl_est_pkg::SEL_W-1:0]     wr_sel,
  input  logic signed [CW-1:0]              wr_data,
  input  logic                              snap,
  output logic signed [CW-1:0]              hp_ff0,
  output logic signed [CW-1:0]              hp_ff1,
  output logic signed [CW-1:0]              hp_fb,
  output logic signed [CW-1:0]              lp_ff0,
  output logic signed [CW-1:0]              lp_ff1,
  output logic signed [CW-1:0]              lp_fb
);
  import lvl_est_pkg::*;

  logic signed [CW-1:0] shd [NCOEF];
  logic signed [CW-1:0] lp_act [3];

  // staged copy: writes land here at any time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) shd[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCOEF; i++)
        if (wr_sel == SEL_W'(i)) shd[i] <= wr_data;
    end
  end

  // low-pass set frozen when the sample enters the high-pass stage
  generate
    for (genvar k = 0; k < 3; k++) begin : g_snap
      always_ff @(posedge clk) begin
        if (!rst_n)    lp_act[k] <= '0;
        else if (snap) lp_act[k] <= shd[int'(CS_LP_FF0) + k];
      end
    end
  endgenerate

  assign hp_ff0 = shd[CS_HP_FF0];
  assign hp_ff1 = shd[CS_HP_FF1];
  assign hp_fb  = shd[CS_HP_FB];
  assign lp_ff0 = lp_act[0];
  assign lp_ff1 = lp_act[1];
  assign lp_fb  = lp_act[2];
endmodule

// File: rtl/lvl_iir_sec.sv
module lvl_iir_sec #(
  parameter int SW   = 24,
  parameter int CW   = 24,
  parameter int FRAC = 23,
  parameter int GW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 smp_vld,
  input  logic signed [SW-1:0] smp_x,
  input  logic signed [CW-1:0] c_ff0,
  input  logic signed [CW-1:0] c_ff1,
  input  logic signed [CW-1:0] c_fb,
  output logic                 y_vld,
  output logic signed [SW-1:0] y,
  output logic                 sat_evt
);
  localparam int PW = SW + CW;
  localparam int AW = PW + GW;
  localparam logic signed [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};
  localparam logic signed [AW-1:0] HALF = ONE <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (ONE <<< (SW - 1)) - ONE;
  localparam logic signed [AW-1:0] MINV = -MAXV - ONE;

  logic signed [SW-1:0] xp, yp;
  logic signed [AW-1:0] acc, shifted;
  logic signed [SW-1:0] y_new;

  function automatic logic signed [AW-1:0] mac3(
    input logic signed [CW-1:0] a0, input logic signed [SW-1:0] v0,
    input logic signed [CW-1:0] a1, input logic signed [SW-1:0] v1,
    input logic signed [CW-1:0] a2, input logic signed [SW-1:0] v2);
    logic signed [PW-1:0] p0, p1, p2;
    logic signed [AW-1:0] s;
    p0 = PW'(a0) * PW'(v0);
    p1 = PW'(a1) * PW'(v1);
    p2 = PW'(a2) * PW'(v2);
    s = AW'(p0);
    s = s + AW'(p1);
    s = s + AW'(p2);
    return s;
  endfunction

  function automatic logic signed [AW-1:0] rnd_shift(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] b;
    b = a + HALF;
    return b >>> FRAC;
  endfunction

  function automatic logic signed [SW-1:0] clip(input logic signed [AW-1:0] a);
    if (a > MAXV)      return MAXV[SW-1:0];
    else if (a < MINV) return MINV[SW-1:0];
    else               return a[SW-1:0];
  endfunction

  always_comb begin
    acc     = mac3(c_ff0, smp_x, c_ff1, xp, c_fb, yp);
    shifted = rnd_shift(acc);
    y_new   = clip(shifted);
    sat_evt = (shifted > MAXV) || (shifted < MINV);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      xp    <= '0;
      yp    <= '0;
      y_vld <= 1'b0;
    end else begin
      y_vld <= smp_vld;
      if (smp_vld) begin
        xp <= smp_x;
        yp <= y_new;
      end
    end
  end

  assign y = yp;
endmodule

// File: rtl/lvl_est_iir.sv
module lvl_est_iir #(
  parameter int SAMPLE_W = 24,
  parameter int COEF_W   = 24,
  parameter int FRAC_W   = 23,
  parameter int GUARD_W  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                enable,
  input  logic                                in_vld,
  input  logic signed [SAMPLE_W-1:0]          in_data,
  input  logic                                cfg_we,
  input  logic [lvl_est_pkg::SEL_W-1:0]       cfg_sel,
  input  logic signed [COEF_W-1:0]            cfg_data,
  output logic                                out_vld,
  output logic signed [SAMPLE_W-1:0]          out_data
);
  logic smp_go, clr;
  logic signed [COEF_W-1:0] hp_n0, hp_n1, hp_d1, lp_n0, lp_n1, lp_d1;
  logic hp_vld, hp_sat, lp_sat;
  logic signed [SAMPLE_W-1:0] hp_y;

  assign smp_go = in_vld & enable;
  assign clr    = ~enable;

  lvl_coef_bank #(.CW(COEF_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_data),
    .snap(smp_go),
    .hp_ff0(hp_n0), .hp_ff1(hp_n1), .hp_fb(hp_d1),
    .lp_ff0(lp_n0), .lp_ff1(lp_n1), .lp_fb(lp_d1)
  );

  lvl_iir_sec #(.SW(SAMPLE_W), .CW(COEF_W), .FRAC(FRAC_W), .GW(GUARD_W)) u_hpf (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .smp_vld(smp_go), .smp_x(in_data),
    .c_ff0(hp_n0), .c_ff1(hp_n1), .c_fb(hp_d1),
    .y_vld(hp_vld), .y(hp_y), .sat_evt(hp_sat)
  );

  lvl_iir_sec #(.SW(SAMPLE_W), .CW(COEF_W), .FRAC(FRAC_W), .GW(GUARD_W)) u_lpf (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .smp_vld(hp_vld), .smp_x(hp_y),
    .c_ff0(lp_n0), .c_ff1(lp_n1), .c_fb(lp_d1),
    .y_vld(out_vld), .y(out_data), .sat_evt(lp_sat)
  );
endmodule

// File: rtl/lvl_est_chk.sv
module lvl_est_chk #(
  parameter int SW = 24,
  parameter int CW = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic                 in_vld,
  input logic                 out_vld,
  input logic signed [SW-1:0] out_data,
  input logic                 hp_vld,
  input logic signed [SW-1:0] hp_y,
  input logic                 hp_sat,
  input logic                 lp_sat,
  input logic signed [CW-1:0] lp_n0,
  input logic signed [CW-1:0] lp_n1,
  input logic signed [CW-1:0] lp_d1
);
  localparam logic signed [SW-1:0] SMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(enable, 2)) |-> (out_vld == $past(in_vld, 2))); // R4

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_vld && out_data == '0 && hp_y == '0)); // R6

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !out_vld) |-> $stable(out_data)); // R5

  AST_COEF_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_vld && enable) |=> ($stable(lp_n0) && $stable(lp_n1) && $stable(lp_d1))); // R7

  AST_HP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_sat && in_vld && enable) |=> (hp_y == SMAX || hp_y == SMIN)); // R2

  AST_LP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_sat && hp_vld && enable) |=> (out_data == SMAX || out_data == SMIN)); // R2
endmodule

bind lvl_est_iir lvl_est_chk #(.SW(SAMPLE_W), .CW(COEF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .in_vld(in_vld),
  .out_vld(out_vld), .out_data(out_data),
  .hp_vld(hp_vld), .hp_y(hp_y), .hp_sat(hp_sat), .lp_sat(lp_sat),
  .lp_n0(lp_n0), .lp_n1(lp_n1), .lp_d1(lp_d1)
);

// File: tb/tb_lvl_est_iir.sv
`timescale 1ns/1ps
module tb_lvl_est_iir;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic in_vld = 1'b0;
  logic signed [23:0] in_data = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic signed [23:0] cfg_data = '0;
  logic out_vld;
  logic signed [23:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  longint cf [6];
  longint hx1, hy1, lx1, ly1;

  always #2 clk = ~clk;

  lvl_est_iir dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_vld(in_vld), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  function automatic longint sect(longint a0, longint a1, longint a2,
                                  longint x, longint xp, longint yp);
    longint s, r;
    s = a0 * x + a1 * xp + a2 * yp;
    r = (s + 64'sd4194304) >>> 23;
    if (r > 8388607)  r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  function automatic longint model_step(longint x);
    longint h, l;
    h = sect(cf[0], cf[1], cf[2], x, hx1, hy1);
    hx1 = x; hy1 = h;
    l = sect(cf[3], cf[4], cf[5], h, lx1, ly1);
    lx1 = h; ly1 = l;
    return l;
  endfunction

  function automatic longint outv();
    return longint'(out_data);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_coef(int sel, longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = 24'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 6) cf[sel] = val;
  endtask

  task automatic clear_state();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    hx1 = 0; hy1 = 0; lx1 = 0; ly1 = 0;
  endtask

  task automatic push_chk(longint x, string req);
    longint e;
    @(negedge clk);
    in_vld = 1'b1; in_data = 24'(x);
    e = model_step(x);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b1 && outv() == e, req, outv(), e);
    @(negedge clk);
    check(out_vld == 1'b0 && outv() == e, "R5", outv(), e);
  endtask

  task automatic t_reset();
    check(out_vld == 1'b0 && outv() == 0, "R9", outv(), 0);
    push_chk(1000, "R9");
  endtask

  task automatic t_round();
    wr_coef(0, 1);
    wr_coef(3, 8388607);
    clear_state();
    push_chk(4194304, "R1");
    push_chk(4194303, "R1");
    push_chk(-4194304, "R1");
    push_chk(-4194305, "R1");
  endtask

  task automatic t_order();
    wr_coef(0, 4194304);
    wr_coef(1, -4194304);
    wr_coef(2, 7549747);
    wr_coef(3, 1048576);
    wr_coef(4, 1048576);
    wr_coef(5, 6291456);
    clear_state();
    push_chk(3000000, "R1");
    push_chk(3000000, "R1");
    push_chk(3000000, "R1");
    push_chk(-2500000, "R1");
    push_chk(123457, "R1");
  endtask

  task automatic t_sat();
    wr_coef(0, 8388607); wr_coef(1, 8388607); wr_coef(2, 0);
    wr_coef(3, 8388607); wr_coef(4, 0); wr_coef(5, 0);
    clear_state();
    push_chk(8388607, "R2");
    push_chk(8388607, "R2");
    push_chk(-8388608, "R2");
    push_chk(-8388608, "R2");
  endtask

  task automatic t_wide();
    wr_coef(0, -8388608); wr_coef(1, -8388608); wr_coef(2, 8388607);
    clear_state();
    push_chk(-8388608, "R3");
    push_chk(-8388608, "R3");
    push_chk(-8388608, "R3");
  endtask

  task automatic t_burst();
    longint xs [4];
    longint e [4];
    xs[0] = 100000; xs[1] = -700000; xs[2] = 2500000; xs[3] = 42;
    wr_coef(0, 4194304); wr_coef(1, -4194304); wr_coef(2, 7549747);
    wr_coef(3, 1048576); wr_coef(4, 1048576); wr_coef(5, 6291456);
    clear_state();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) check(out_vld == 1'b1 && outv() == e[i-2], "R4", outv(), e[i-2]);
      if (i < 4) begin
        in_vld = 1'b1; in_data = 24'(xs[i]);
        e[i] = model_step(xs[i]);
      end else begin
        in_vld = 1'b0;
      end
    end
    @(negedge clk);
    check(out_vld == 1'b0, "R4", longint'(out_vld), 0);
  endtask

  task automatic t_atomic();
    longint e;
    @(negedge clk);
    in_vld = 1'b1; in_data = 24'(1500000);
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_data = 24'(8000000);
    e = model_step(1500000);
    cf[3] = 8000000;
    @(negedge clk);
    in_vld = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b1 && outv() == e, "R7", outv(), e);
    push_chk(1500000, "R7");
    wr_coef(4, -3000000);
    push_chk(-900000, "R7");
  endtask

  task automatic t_ignore();
    wr_coef(6, 8388607);
    wr_coef(7, -8388608);
    push_chk(777777, "R8");
    push_chk(-55555, "R8");
  endtask

  task automatic t_disable();
    @(negedge clk);
    enable = 1'b0; in_vld = 1'b1; in_data = 24'(5000000);
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0 && outv() == 0, "R6", outv(), 0);
    enable = 1'b1;
    hx1 = 0; hy1 = 0; lx1 = 0; ly1 = 0;
    push_chk(2000000, "R6");
    push_chk(2000000, "R6");
    @(negedge clk);
    in_vld = 1'b1; in_data = 24'(3000000);
    @(negedge clk);
    in_vld = 1'b0; enable = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0 && outv() == 0, "R6", outv(), 0);
    enable = 1'b1;
    hx1 = 0; hy1 = 0; lx1 = 0; ly1 = 0;
    push_chk(2000000, "R6");
  endtask

  initial begin
    for (int i = 0; i < 6; i++) cf[i] = 0;
    hx1 = 0; hy1 = 0; lx1 = 0; ly1 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round();
    t_order();
    t_sat();
    t_wide();
    t_burst();
    t_atomic();
    t_ignore();
    t_disable();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule